// File: doc/BRIEF.md
# Quad-to-Warp Batch Packer

The packer sits between several parallel rasterizer output streams and a single shader dispatch port. Each stream delivers 2x2 pixel quads, each quad with an X/Y screen position, a 4-bit per-pixel coverage mask and a tag naming the shader state it must run with. The packer gathers quads into fixed-size shading batches of `QUADS` quads (four threads per quad, 32 threads for the default of 8 quads). It hands each batch to the dispatch port under a valid/ready handshake.

A batch leaves when it is full. It leaves early, partially filled, when the next quad selected carries a different shader tag or when a flush is requested. All four pixels of an accepted quad take lanes in the batch, whether or not their coverage bit is set, because uncovered helper pixels are still shaded for derivatives. The output therefore carries two masks. A lane-valid mask marks lanes that hold a quad's pixel. A coverage mask marks the pixels that are really covered. Unused lanes of a partial batch can then be told apart from helper lanes.

The control is a two-state machine. In `ST_FILL` the round-robin arbiter offers one stream's quad per cycle, and the quad is accepted if the batch is empty or its tag matches. In `ST_ISSUE` the batch is presented on the output and every input is back-pressured. The transitions are: `FILL_TO_ISSUE_FULL` (the last slot is written), `FILL_TO_ISSUE_TAG` (the selected quad's tag differs from a non-empty batch), `FILL_TO_ISSUE_FLUSH` (a flush with at least one quad held), `ISSUE_TO_FILL` (the output handshake completes), and `FILL_STAY` / `ISSUE_STAY` otherwise.

Top module: `quad_batch_packer`

## Requirements
- R1: After reset, `out_valid` is 0, `out_lane_valid` is all zeros and no `in_ready` bit is set.
- R2: When `QUADS` quads with one tag have been accepted, the packer presents them one cycle later as a batch with every lane-valid bit set, without waiting for a flush.
- R3: The k-th accepted quad of a batch takes slot k: position in `out_qx[k*XW +: XW]` / `out_qy[k*YW +: YW]`, lanes 4k..4k+3 in both masks, coverage bit j (pixel j of the quad) on lane 4k+j. Its four lane-valid bits are set even when its coverage bits are 0.
- R4: Streams are served round-robin. The stream granted is the first stream with `in_valid` set, searching upward from the one after the last accepted stream and wrapping past the highest index. `in_ready` is only set for a stream whose `in_valid` is set.
- R5: Quads from one stream appear in the issued batches in the order that stream offered them.
- R6: If the selected quad's tag differs from that of a non-empty batch, that quad is not accepted. The batch is issued partially, and the quad then opens the next batch, whose `out_tag` is its tag.
- R7: A `flush_req` seen in `ST_FILL` with a non-empty batch issues the batch as it is. Lanes of empty slots have lane-valid 0, coverage 0, and position fields 0. No quad is accepted in a cycle with `flush_req` high.
- R8: A `flush_req` with an empty batch issues nothing. Every issued batch holds at least one quad.
- R9: While `out_valid` is high, all `in_ready` bits are 0. While `out_ready` is low, `out_valid` and the whole payload stay unchanged.
- R10: At most one `in_ready` bit is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | N_STREAMS | Per-stream quad valid |
| in_ready | output | N_STREAMS | Per-stream quad accept |
| in_x | input | N_STREAMS*XW | Per-stream quad X position, stream s at [s*XW +: XW] |
| in_y | input | N_STREAMS*YW | Per-stream quad Y position |
| in_cov | input | N_STREAMS*4 | Per-stream 4-bit pixel coverage |
| in_tag | input | N_STREAMS*TW | Per-stream shader-state tag |
| flush_req | input | 1 | Request to close the batch in progress |
| out_valid | output | 1 | Batch valid |
| out_ready | input | 1 | Dispatch port accepts batch |
| out_tag | output | TW | Shader-state tag of the batch |
| out_qx | output | QUADS*XW | Quad X positions by slot |
| out_qy | output | QUADS*YW | Quad Y positions by slot |
| out_lane_valid | output | QUADS*4 | Lanes holding a quad's pixel |
| out_cov | output | QUADS*4 | Lanes whose pixel is covered |

## Verification
The bench builds the packer with three input streams, eight quads per batch, 10-bit positions and a 3-bit tag. A stream count that is not a power of two makes the round-robin pointer wrap from stream 2 back to stream 0 without passing through an unused index. The narrow tag makes matching and mismatching tags both common under random tag drift. With eight slots, full batches, tag-closed partial batches and flush-closed partial batches all occur many times in a short run.

// File: rtl/qbp_pkg.sv
package qbp_pkg;
    localparam int PIX_PER_QUAD = 4;

    typedef enum logic [0:0] {
        ST_FILL  = 1'b0,
        ST_ISSUE = 1'b1
    } qbp_state_e;
endpackage

// File: rtl/qbp_rr_arb.sv
module qbp_rr_arb #(
    parameter int N  = 3,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          advance,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] grant_idx,
    output logic          any_req
);
    logic [IW-1:0] ptr_q;

    // Search from the pointer upward; smallest offset wins.
    always_comb begin
        int idx;
        grant_idx = ptr_q;
        any_req   = 1'b0;
        for (int off = N - 1; off >= 0; off--) begin
            idx = (int'(ptr_q) + off) % N;
            if (req[idx]) begin
                grant_idx = IW'(idx);
                any_req   = 1'b1;
            end
        end
        grant = any_req ? (N'(1) << grant_idx) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (advance) begin
            if (int'(grant_idx) == N - 1) ptr_q <= '0;
            else                          ptr_q <= grant_idx + 1'b1;
        end
    end
endmodule

// File: rtl/qbp_batch_store.sv
module qbp_batch_store #(
    parameter int Q  = 8,
    parameter int XW = 12,
    parameter int YW = 12,
    parameter int SW = $clog2(Q)
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic [SW-1:0]   wr_slot,
    input  logic [XW-1:0]   wr_x,
    input  logic [YW-1:0]   wr_y,
    input  logic [3:0]      wr_cov,
    output logic [Q*XW-1:0] rd_x,
    output logic [Q*YW-1:0] rd_y,
    output logic [Q*4-1:0]  rd_cov
);
    for (genvar g = 0; g < Q; g++) begin : g_slot
        logic [XW-1:0] x_q;
        logic [YW-1:0] y_q;
        logic [3:0]    c_q;
        always_ff @(posedge clk) begin
            if (wr_en && wr_slot == SW'(g)) begin
                x_q <= wr_x;
                y_q <= wr_y;
                c_q <= wr_cov;
            end
        end
        assign rd_x[g*XW +: XW] = x_q;
        assign rd_y[g*YW +: YW] = y_q;
        assign rd_cov[g*4 +: 4] = c_q;
    end
endmodule

// File: rtl/quad_batch_packer.sv
module quad_batch_packer
    import qbp_pkg::*;
#(
    parameter int N_STREAMS = 3,
    parameter int QUADS     = 8,
    parameter int XW        = 12,
    parameter int YW        = 12,
    parameter int TW        = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_STREAMS-1:0]      in_valid,
    output logic [N_STREAMS-1:0]      in_ready,
    input  logic [N_STREAMS*XW-1:0]   in_x,
    input  logic [N_STREAMS*YW-1:0]   in_y,
    input  logic [N_STREAMS*4-1:0]    in_cov,
    input  logic [N_STREAMS*TW-1:0]   in_tag,
    input  logic                      flush_req,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [TW-1:0]             out_tag,
    output logic [QUADS*XW-1:0]       out_qx,
    output logic [QUADS*YW-1:0]       out_qy,
    output logic [QUADS*PIX_PER_QUAD-1:0] out_lane_valid,
    output logic [QUADS*PIX_PER_QUAD-1:0] out_cov
);
    localparam int LANES = QUADS * PIX_PER_QUAD;
    localparam int CW    = $clog2(QUADS + 1);
    localparam int SW    = $clog2(QUADS);
    localparam int IW    = $clog2(N_STREAMS);

    qbp_state_e state_q, state_d;
    logic [CW-1:0] count_q;
    logic [TW-1:0] tag_q;

    logic [N_STREAMS-1:0] grant;
    logic [IW-1:0]        gidx;
    logic                 any_req;
    logic [TW-1:0]        sel_tag;
    logic                 tag_ok, accept, close_tag, close_flush, last_slot;
    logic [QUADS*XW-1:0]  st_x;
    logic [QUADS*YW-1:0]  st_y;
    logic [LANES-1:0]     st_cov;
    logic [QUADS-1:0]     occupied;

    qbp_rr_arb #(.N(N_STREAMS), .IW(IW)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (in_valid),
        .advance   (accept),
        .grant     (grant),
        .grant_idx (gidx),
        .any_req   (any_req)
    );

    qbp_batch_store #(.Q(QUADS), .XW(XW), .YW(YW), .SW(SW)) u_store (
        .clk     (clk),
        .wr_en   (accept),
        .wr_slot (SW'(count_q)),
        .wr_x    (in_x[gidx*XW +: XW]),
        .wr_y    (in_y[gidx*YW +: YW]),
        .wr_cov  (in_cov[gidx*4 +: 4]),
        .rd_x    (st_x),
        .rd_y    (st_y),
        .rd_cov  (st_cov)
    );

    assign sel_tag     = in_tag[gidx*TW +: TW];
    assign tag_ok      = (count_q == '0) || (sel_tag == tag_q);
    assign last_slot   = (count_q == CW'(QUADS - 1));
    assign accept      = (state_q == ST_FILL) && !flush_req && any_req && tag_ok;
    assign close_tag   = (state_q == ST_FILL) && !flush_req && any_req && !tag_ok;
    assign close_flush = (state_q == ST_FILL) && flush_req && (count_q != '0);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: begin
                if ((accept && last_slot) || close_tag || close_flush)
                    state_d = ST_ISSUE;          // FILL_TO_ISSUE_*
            end
            ST_ISSUE: begin
                if (out_ready) state_d = ST_FILL; // ISSUE_TO_FILL
            end
            default: state_d = ST_FILL;
        endcase
    end

    // State register and batch bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
            count_q <= '0;
            tag_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_ISSUE && out_ready) begin
                count_q <= '0;
            end else if (accept) begin
                count_q <= count_q + 1'b1;
                if (count_q == '0) tag_q <= sel_tag;
            end
        end
    end

    for (genvar g = 0; g < QUADS; g++) begin : g_lane
        assign occupied[g] = (CW'(g) < count_q);
    end

    // Outputs
    always_comb begin
        out_valid = (state_q == ST_ISSUE);
        in_ready  = accept ? grant : '0;
        out_tag   = tag_q;
        for (int k = 0; k < QUADS; k++) begin
            out_lane_valid[k*PIX_PER_QUAD +: PIX_PER_QUAD] = {PIX_PER_QUAD{occupied[k]}};
            out_cov[k*PIX_PER_QUAD +: PIX_PER_QUAD] =
                st_cov[k*PIX_PER_QUAD +: PIX_PER_QUAD] & {PIX_PER_QUAD{occupied[k]}};
            out_qx[k*XW +: XW] = st_x[k*XW +: XW] & {XW{occupied[k]}};
            out_qy[k*YW +: YW] = st_y[k*YW +: YW] & {YW{occupied[k]}};
        end
    end
endmodule

// File: rtl/qbp_checker.sv
module qbp_checker #(
    parameter int N_STREAMS = 3,
    parameter int QUADS     = 8,
    parameter int XW        = 12,
    parameter int YW        = 12,
    parameter int TW        = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [N_STREAMS-1:0]    in_valid,
    input logic [N_STREAMS-1:0]    in_ready,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic [TW-1:0]           out_tag,
    input logic [QUADS*XW-1:0]     out_qx,
    input logic [QUADS*YW-1:0]     out_qy,
    input logic [QUADS*4-1:0]      out_lane_valid,
    input logic [QUADS*4-1:0]      out_cov
);
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_tag) &&
            $stable(out_qx) && $stable(out_qy) &&
            $stable(out_lane_valid) && $stable(out_cov)));

    p_backpressure_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (in_ready == '0));

    p_single_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_ready));

    p_ready_needs_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready & ~in_valid) == '0);

    p_nonempty_issue_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_lane_valid[3:0] == 4'hF));

    p_cov_in_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_cov & ~out_lane_valid) == '0));
endmodule

bind quad_batch_packer qbp_checker #(
    .N_STREAMS (N_STREAMS),
    .QUADS     (QUADS),
    .XW        (XW),
    .YW        (YW),
    .TW        (TW)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_ready       (in_ready),
    .out_valid      (out_valid),
    .out_ready      (out_ready),
    .out_tag        (out_tag),
    .out_qx         (out_qx),
    .out_qy         (out_qy),
    .out_lane_valid (out_lane_valid),
    .out_cov        (out_cov)
);

// File: tb/quad_batch_packer_tb.sv
module quad_batch_packer_tb;
    localparam int NS = 3;
    localparam int Q  = 8;
    localparam int XW = 10;
    localparam int YW = 10;
    localparam int TW = 3;
    localparam int L  = Q * 4;

    typedef struct packed {
        logic [TW-1:0]   tag;
        logic [L-1:0]    lv;
        logic [L-1:0]    cov;
        logic [Q*XW-1:0] qx;
        logic [Q*YW-1:0] qy;
    } batch_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NS-1:0]    in_valid = '0;
    logic [NS-1:0]    in_ready;
    logic [NS*XW-1:0] in_x = '0;
    logic [NS*YW-1:0] in_y = '0;
    logic [NS*4-1:0]  in_cov = '0;
    logic [NS*TW-1:0] in_tag = '0;
    logic             flush_req = 1'b0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [TW-1:0]    out_tag;
    logic [Q*XW-1:0]  out_qx;
    logic [Q*YW-1:0]  out_qy;
    logic [L-1:0]     out_lane_valid;
    logic [L-1:0]     out_cov;

    always #5 clk = ~clk;

    quad_batch_packer #(.N_STREAMS(NS), .QUADS(Q), .XW(XW), .YW(YW), .TW(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_x(in_x), .in_y(in_y), .in_cov(in_cov), .in_tag(in_tag),
        .flush_req(flush_req), .out_valid(out_valid), .out_ready(out_ready),
        .out_tag(out_tag), .out_qx(out_qx), .out_qy(out_qy),
        .out_lane_valid(out_lane_valid), .out_cov(out_cov)
    );

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic [NS-1:0] acc = '0;
    batch_t exp_q[$];
    batch_t act_q[$];
    batch_t cur;
    int     cur_n = 0;
    int     exp_ptr = 0;
    logic   prev_stall = 1'b0;
    batch_t held;
    logic   mon_on = 1'b0;

    task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, expv);
        end
    endtask

    function automatic batch_t snap_out();
        batch_t b;
        b.tag = out_tag; b.lv = out_lane_valid; b.cov = out_cov;
        b.qx = out_qx; b.qy = out_qy;
        return b;
    endfunction

    function automatic batch_t empty_batch();
        batch_t b;
        b = '0;
        return b;
    endfunction

    // Reference packing model and port monitor
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            // R9: hold while stalled, no ready while issuing
            if (prev_stall) begin
                check(out_valid && (snap_out() == held), "R9 batch held under stall",
                      {31'b0, out_valid}, 64'h1);
            end
            if (out_valid && in_ready != '0)
                check(1'b0, "R9 in_ready during issue", 64'(in_ready), 64'h0);
            if ($countones(in_ready) > 1)
                check(1'b0, "R10 multiple grants", 64'(in_ready), 64'h0);
            if ((in_ready & ~in_valid) != '0)
                check(1'b0, "R4 ready without valid", 64'(in_ready), 64'(in_valid));
            prev_stall = out_valid && !out_ready;
            held = snap_out();
            if (out_valid && out_ready) act_q.push_back(snap_out());
            if (out_valid && out_lane_valid[3:0] != 4'hF)
                check(1'b0, "R8 empty batch issued", 64'(out_lane_valid), 64'hF);

            acc = in_valid & in_ready;
            if (flush_req && !out_valid) begin
                if (in_ready != '0) check(1'b0, "R7 accept during flush", 64'(in_ready), 64'h0);
                if (cur_n > 0) begin exp_q.push_back(cur); cur = empty_batch(); cur_n = 0; end
            end else if (in_ready != '0) begin
                int s;
                int e;
                s = 0;
                for (int i = 0; i < NS; i++) if (in_ready[i]) s = i;
                e = -1;
                for (int o = NS - 1; o >= 0; o--) if (in_valid[(exp_ptr + o) % NS]) e = (exp_ptr + o) % NS;
                check(s == e, "R4 round-robin grant", 64'(s), 64'(e));
                exp_ptr = (s + 1) % NS;
                if (cur_n > 0 && in_tag[s*TW +: TW] != cur.tag) begin
                    exp_q.push_back(cur); cur = empty_batch(); cur_n = 0;
                end
                // R3: slot k holds position, lanes 4k..4k+3 all valid
                cur.tag = in_tag[s*TW +: TW];
                cur.qx[cur_n*XW +: XW] = in_x[s*XW +: XW];
                cur.qy[cur_n*YW +: YW] = in_y[s*YW +: YW];
                cur.lv[cur_n*4 +: 4]   = 4'hF;
                cur.cov[cur_n*4 +: 4]  = in_cov[s*4 +: 4];
                cur_n++;
                if (cur_n == Q) begin exp_q.push_back(cur); cur = empty_batch(); cur_n = 0; end
            end
            while (exp_q.size() > 0 && act_q.size() > 0) begin
                batch_t a;
                batch_t x;
                a = act_q.pop_front();
                x = exp_q.pop_front();
                check(a == x, "R2 R3 R5 R6 R7 batch content", 64'(a.lv), 64'(x.lv));
                if (a != x) $display("FAIL R6 tag/cov detail actual tag=%0d cov=%h expected tag=%0d cov=%h",
                                     a.tag, a.cov, x.tag, x.cov);
            end
        end else begin
            acc = '0;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic send_quad(input int s, input logic [XW-1:0] x, input logic [YW-1:0] y,
                             input logic [3:0] c, input logic [TW-1:0] t);
        in_x[s*XW +: XW] = x; in_y[s*YW +: YW] = y;
        in_cov[s*4 +: 4] = c; in_tag[s*TW +: TW] = t;
        in_valid[s] = 1'b1;
        do step(); while (!acc[s]);
        in_valid[s] = 1'b0;
    endtask

    task automatic pulse_flush();
        flush_req = 1'b1; step(); flush_req = 1'b0;
    endtask

    logic [TW-1:0] rtag;

    initial begin
        void'($urandom(32'h5eed_1234));
        cur = empty_batch();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(out_valid == 1'b0, "R1 out_valid after reset", 64'(out_valid), 64'h0);
        check(out_lane_valid == '0, "R1 lane mask after reset", 64'(out_lane_valid), 64'h0);
        check(in_ready == '0, "R1 in_ready after reset", 64'(in_ready), 64'h0);
        mon_on = 1'b1;
        step();

        // R8: flush on empty batch issues nothing
        pulse_flush();
        repeat (3) step();
        @(negedge clk);
        check(out_valid == 1'b0, "R8 flush of empty batch", 64'(out_valid), 64'h0);
        step();

        // R3/R7: three quads (one helper-only), flush, held by stall
        out_ready = 1'b0;
        send_quad(0, 10'd5, 10'd6, 4'b0001, 3'd2);
        send_quad(1, 10'd7, 10'd8, 4'b0000, 3'd2);
        send_quad(2, 10'd9, 10'd10, 4'b1110, 3'd2);
        pulse_flush();
        @(negedge clk);
        check(out_valid == 1'b1, "R7 partial batch on flush", 64'(out_valid), 64'h1);
        check(out_lane_valid == 32'h0000_0FFF, "R3 helper lanes kept valid", 64'(out_lane_valid), 64'hFFF);
        check(out_cov == 32'h0000_0E01, "R3 coverage lane placement", 64'(out_cov), 64'hE01);
        check(out_qx[XW +: XW] == 10'd7, "R3 slot position", 64'(out_qx[XW +: XW]), 64'd7);
        step();
        out_ready = 1'b1; step(); out_ready = 1'b0;

        // R2/R9: full batch under stall, pending quad back-pressured
        for (int k = 0; k < Q; k++) send_quad(k % NS, 10'(k + 100), 10'(k + 200), 4'(k), 3'd4);
        @(negedge clk);
        check(out_valid == 1'b1, "R2 full batch issued", 64'(out_valid), 64'h1);
        check(out_lane_valid == '1, "R2 full lane mask", 64'(out_lane_valid), 64'hFFFF_FFFF);
        check(out_tag == 3'd4, "R2 batch tag", 64'(out_tag), 64'd4);
        in_valid[0] = 1'b1; in_tag[0 +: TW] = 3'd4;
        repeat (3) step();
        @(negedge clk);
        check(in_ready == '0, "R9 backpressure while stalled", 64'(in_ready), 64'h0);
        step();
        in_valid[0] = 1'b0;
        out_ready = 1'b1; step();

        // R6: tag change closes partial batch
        send_quad(1, 10'd1, 10'd1, 4'hF, 3'd1);
        send_quad(1, 10'd2, 10'd2, 4'hF, 3'd1);
        send_quad(2, 10'd3, 10'd3, 4'h3, 3'd6);
        @(negedge clk);
        check(out_valid == 1'b0 && out_lane_valid == 32'h0000_000F,
              "R6 new batch opened by tag change", 64'(out_lane_valid), 64'hF);
        check(out_tag == 3'd6, "R6 new batch tag", 64'(out_tag), 64'd6);
        step();
        pulse_flush();
        repeat (3) step();

        // Random phase
        rtag = 3'd0;
        for (int c = 0; c < 20000; c++) begin
            step();
            if ($urandom % 50 == 0) rtag = 3'($urandom);
            out_ready = ($urandom % 10) < 7;
            flush_req = ($urandom % 60) == 0;
            for (int s = 0; s < NS; s++) begin
                if (acc[s]) in_valid[s] = 1'b0;
                if (!in_valid[s] && ($urandom % 3) == 0) begin
                    in_x[s*XW +: XW] = 10'($urandom);
                    in_y[s*YW +: YW] = 10'($urandom);
                    in_cov[s*4 +: 4] = 4'($urandom);
                    in_tag[s*TW +: TW] = rtag;
                    in_valid[s] = 1'b1;
                end
            end
        end
        // Drain
        step();
        for (int s = 0; s < NS; s++) if (acc[s]) in_valid[s] = 1'b0;
        flush_req = 1'b0;
        out_ready = 1'b1;
        while (in_valid != '0) begin
            step();
            for (int s = 0; s < NS; s++) if (acc[s]) in_valid[s] = 1'b0;
        end
        repeat (3) step();
        pulse_flush();
        repeat (5) step();
        @(negedge clk);
        check(exp_q.size() == 0 && act_q.size() == 0 && cur_n == 0,
              "R5 all quads issued in order", 64'(act_q.size()), 64'(exp_q.size()));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule